// File: doc/BRIEF.md
# Catch-up Interrupt Countdown Timer

This block is a local interrupt timer that counts down by an elapsed-tick amount rather than one tick per clock. Each accepted update may advance time by many ticks. When the count would pass zero, the timer expires and posts its 8-bit vector as a one-cycle request toward the local interrupt request tracker. The timer always uses fixed delivery, and a mask bit can silence the request.

In periodic mode, a single large update can overrun several whole periods. The block finds out how many periods were skipped and what is left of the current period, using a sequential divider. It adds the skipped periods to a saturating missed-interrupt counter. Later, on any update that does not expire, while the tracker reports nothing pending, it replays those interrupts one per update. While the divider runs, a busy flag is raised and new tick updates are dropped.

Software programs the reload value, the running count and a control word through a single write port. A prescale shift scales the elapsed ticks before they are used.

Top module: `ctmr_timer`

## Requirements
- R1: After reset, the reload value, running count and missed counter read zero, and both `irq_valid` and `busy` are low.
- R2: Writes take effect on the clock edge where `wr_en` is high, selected by `wr_sel`. Code 0 loads the reload value and also the running count. Code 1 loads only the running count. Code 2 loads the control word: bits 7:0 are the vector, bit 8 selects periodic mode (1) or one-shot mode (0), and bit 9 is the mask.
- R3: An accepted update whose scaled ticks are below the running count reduces the count by that amount and raises no expiry request.
- R4: An accepted update whose scaled ticks are at least the running count is an expiry. The count goes to zero and, if unmasked, `irq_valid` is high for the cycle after the update edge with `irq_vector` equal to the control vector. In one-shot mode the count then stays at zero.
- R5: When the mask bit is set, an expiry raises no request, but the count and missed-counter arithmetic still proceed.
- R6: On a periodic expiry, let the surplus be the scaled ticks minus the running count. `busy` rises for exactly CW cycles. When it falls, the missed counter has grown by surplus / reload, and the count equals reload − (surplus mod reload).
- R7: On an accepted non-expiring update with a nonzero missed counter, `irq_pend` low and the mask clear, one request carrying the vector is raised and the missed counter drops by one. If `irq_pend` is high or the mask is set, no request is raised and the counter is unchanged.
- R8: With a reload value of zero, updates are ignored. In one-shot mode with a running count of zero, updates are also ignored: no request is raised and the count is unchanged.
- R9: A tick update presented while `busy` is high is dropped. It changes neither the count nor the missed counter, and it raises no request.
- R10: The missed counter saturates at 2^MW − 1.
- R11: The elapsed ticks used by every rule above are `tick_delta` shifted right by `tick_shift`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 reload, 1 running count, 2 control |
| wr_data | input | CW | Write data |
| tick_valid | input | 1 | Elapsed-tick update strobe |
| tick_delta | input | CW | Raw elapsed ticks |
| tick_shift | input | SHIFT_W | Prescale: right shift applied to the ticks |
| irq_pend | input | 1 | Tracker reports an interrupt already pending |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |
| busy | output | 1 | Catch-up division in progress |
| init_count | output | CW | Reload value |
| cur_count | output | CW | Running count |
| missed_count | output | MW | Missed-interrupt counter |

## Verification
The bench builds the block with CW = 16, MW = 4 and SHIFT_W = 3. With MW = 4 the missed counter fills at 15, so a single update with about a hundred overrun periods reaches saturation. With CW = 16, each catch-up division takes 16 cycles, which is short enough to measure the busy window exactly and to inject a dropped update inside it. The 3-bit shift allows prescale factors up to 128 on small tick values.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  // write target codes
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } wsel_e;

  // control word layout: [9] mask, [8] periodic, [7:0] vector
  typedef struct packed {
    logic       mask;
    logic       periodic;
    logic [7:0] vector;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] reload_q,
  output ctrl_t         ctrl_q,
  output logic          reload_wr,
  output logic          count_wr
);

  logic ctrl_wr;

  assign reload_wr = wr_en && (wsel_e'(wr_sel) == SEL_RELOAD);
  assign count_wr  = wr_en && (wsel_e'(wr_sel) == SEL_COUNT);
  assign ctrl_wr   = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (reload_wr) reload_q <= wr_data;
      if (ctrl_wr)   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

endmodule

// File: rtl/ctmr_divider.sv
module ctmr_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         finish,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic [W-1:0] divisor_q
);

  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    q_r, r_r, d_r;
  logic [CNTW-1:0] cnt;
  logic            busy_q;
  logic [W:0]      shifted, diff;
  logic            take;

  // one restoring step per cycle, MSB first
  always_comb begin
    shifted   = {r_r, q_r[W-1]};
    diff      = shifted - {1'b0, d_r};
    take      = !diff[W];
    quotient  = {q_r[W-2:0], take};
    remainder = take ? diff[W-1:0] : shifted[W-1:0];
  end

  assign busy      = busy_q;
  assign finish    = busy_q && (cnt == CNTW'(1));
  assign divisor_q = d_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r    <= '0;
      r_r    <= '0;
      d_r    <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      q_r    <= dividend;
      r_r    <= '0;
      d_r    <= divisor;
      cnt    <= CNTW'(W);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      q_r <= quotient;
      r_r <= remainder;
      cnt <= cnt - CNTW'(1);
      if (finish) busy_q <= 1'b0;
    end
  end

  // R6: a started division keeps busy for the full W steps
  assert_div_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cnt == CNTW'(W)));

endmodule

// File: rtl/ctmr_engine.sv
module ctmr_engine
  import ctmr_pkg::*;
#(
  parameter int CW      = 32,
  parameter int MW      = 8,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_valid,
  input  logic [CW-1:0]      tick_delta,
  input  logic [SHIFT_W-1:0] tick_shift,
  input  logic               irq_pend,
  input  logic [CW-1:0]      reload_q,
  input  ctrl_t              ctrl_q,
  input  logic               reload_wr,
  input  logic               count_wr,
  input  logic [CW-1:0]      wr_data,
  input  logic               div_busy,
  input  logic               div_finish,
  input  logic [CW-1:0]      div_q,
  input  logic [CW-1:0]      div_r,
  input  logic [CW-1:0]      div_d,
  output logic               div_start,
  output logic [CW-1:0]      div_dividend,
  output logic [CW-1:0]      count_q,
  output logic [MW-1:0]      missed_q,
  output logic               irq_valid,
  output logic [7:0]         irq_vector
);

  localparam logic [CW:0] MISS_MAX = {{(CW+1-MW){1'b0}}, {MW{1'b1}}};

  // prescale: elapsed ticks after the shift (R11)
  function automatic logic [CW-1:0] scale_ticks(input logic [CW-1:0] d,
                                                input logic [SHIFT_W-1:0] s);
    return d >> s;
  endfunction

  // saturating add of skipped periods (R10)
  function automatic logic [MW-1:0] add_missed(input logic [MW-1:0] m,
                                               input logic [CW-1:0] q);
    logic [CW:0] sum;
    sum = {{(CW+1-MW){1'b0}}, m} + {1'b0, q};
    return (sum > MISS_MAX) ? {MW{1'b1}} : sum[MW-1:0];
  endfunction

  // named events for the assertions
  logic [CW-1:0] ticks;
  logic          stopped;
  logic          accept;
  logic          expire;
  logic          replay_go;
  logic          irq_fire;

  assign ticks     = scale_ticks(tick_delta, tick_shift);
  assign stopped   = (reload_q == '0) || (!ctrl_q.periodic && count_q == '0);
  assign accept    = tick_valid && !div_busy && !stopped;
  assign expire    = accept && (ticks >= count_q);
  assign replay_go = accept && !expire && (missed_q != '0) && !irq_pend && !ctrl_q.mask;
  assign irq_fire  = (expire && !ctrl_q.mask) || replay_go;

  assign div_start    = expire && ctrl_q.periodic;
  assign div_dividend = ticks - count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q    <= '0;
      missed_q   <= '0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      if (div_finish)     count_q <= div_d - div_r;
      else if (reload_wr) count_q <= wr_data;
      else if (count_wr)  count_q <= wr_data;
      else if (expire)    count_q <= '0;
      else if (accept)    count_q <= count_q - ticks;

      if (div_finish)     missed_q <= add_missed(missed_q, div_q);
      else if (replay_go) missed_q <= missed_q - MW'(1);

      irq_valid  <= irq_fire;
      irq_vector <= irq_fire ? ctrl_q.vector : '0;
    end
  end

  // R9: while dividing, nothing but the result may move the count
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !div_finish && !reload_wr && !count_wr) |=> $stable(count_q));

  // R5: a set mask keeps the request line quiet
  assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.mask && !replay_go) |=> !irq_valid);

  // R7: a replay consumes exactly one missed interrupt and raises a request
  assert_replay_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_go |=> (irq_valid && missed_q == $past(missed_q) - MW'(1)));

  // R6: the reloaded count lies in 1..reload
  assert_reload_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_finish |=> (count_q != '0 && count_q <= $past(div_d)));

  // R8: a zero reload value disables the timer
  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_valid && reload_q == '0 && !div_busy && !reload_wr && !count_wr)
      |=> (!irq_valid && $stable(count_q)));

  // R10: a full counter stays full after a catch-up
  assert_missed_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_finish && missed_q == {MW{1'b1}}) |=> (missed_q == {MW{1'b1}}));

endmodule

// File: rtl/ctmr_timer.sv
module ctmr_timer
  import ctmr_pkg::*;
#(
  parameter int CW      = 32,
  parameter int MW      = 8,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [CW-1:0]      wr_data,
  input  logic               tick_valid,
  input  logic [CW-1:0]      tick_delta,
  input  logic [SHIFT_W-1:0] tick_shift,
  input  logic               irq_pend,
  output logic               irq_valid,
  output logic [7:0]         irq_vector,
  output logic               busy,
  output logic [CW-1:0]      init_count,
  output logic [CW-1:0]      cur_count,
  output logic [MW-1:0]      missed_count
);

  ctrl_t         ctrl_q;
  logic          reload_wr, count_wr;
  logic          div_start, div_busy, div_finish;
  logic [CW-1:0] div_dividend, div_q, div_r, div_d;

  ctmr_regs #(.CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .reload_q  (init_count),
    .ctrl_q    (ctrl_q),
    .reload_wr (reload_wr),
    .count_wr  (count_wr)
  );

  ctmr_divider #(.W(CW)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .dividend  (div_dividend),
    .divisor   (init_count),
    .busy      (div_busy),
    .finish    (div_finish),
    .quotient  (div_q),
    .remainder (div_r),
    .divisor_q (div_d)
  );

  ctmr_engine #(.CW(CW), .MW(MW), .SHIFT_W(SHIFT_W)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_valid   (tick_valid),
    .tick_delta   (tick_delta),
    .tick_shift   (tick_shift),
    .irq_pend     (irq_pend),
    .reload_q     (init_count),
    .ctrl_q       (ctrl_q),
    .reload_wr    (reload_wr),
    .count_wr     (count_wr),
    .wr_data      (wr_data),
    .div_busy     (div_busy),
    .div_finish   (div_finish),
    .div_q        (div_q),
    .div_r        (div_r),
    .div_d        (div_d),
    .div_start    (div_start),
    .div_dividend (div_dividend),
    .count_q      (cur_count),
    .missed_q     (missed_count),
    .irq_valid    (irq_valid),
    .irq_vector   (irq_vector)
  );

  assign busy = div_busy;

  // R1: nothing is requested in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq_valid && !busy && missed_count == '0));

endmodule

// File: tb/ctmr_timer_bench.sv
`timescale 1ns/1ps
module ctmr_timer_bench;

  localparam int CW = 16;
  localparam int MW = 4;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [CW-1:0] wr_data = '0;
  logic          tick_valid = 1'b0;
  logic [CW-1:0] tick_delta = '0;
  logic [SW-1:0] tick_shift = '0;
  logic          irq_pend = 1'b0;
  logic          irq_valid;
  logic [7:0]    irq_vector;
  logic          busy;
  logic [CW-1:0] init_count, cur_count;
  logic [MW-1:0] missed_count;

  always #2.5 clk = ~clk;

  ctmr_timer #(.CW(CW), .MW(MW), .SHIFT_W(SW)) u_ctmr_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick_valid(tick_valid), .tick_delta(tick_delta), .tick_shift(tick_shift),
    .irq_pend(irq_pend), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .busy(busy), .init_count(init_count), .cur_count(cur_count),
    .missed_count(missed_count)
  );

  int checks = 0;
  int fails  = 0;
  logic       got_irq;
  logic [7:0] got_vec;

  typedef struct packed {
    logic [15:0] init;
    logic [15:0] cur;
    logic [15:0] delta;
    logic [2:0]  shift;
    logic        per;
    logic        mask;
    logic        irq;
    logic [15:0] cur_x;
    logic [3:0]  miss_x;
  } vec_t;

  localparam vec_t TBL [0:9] = '{
    '{16'd100, 16'd100, 16'd30,   3'd0, 1'b0, 1'b0, 1'b0, 16'd70,  4'd0 },  // R3 plain countdown
    '{16'd100, 16'd40,  16'd40,   3'd0, 1'b0, 1'b0, 1'b1, 16'd0,   4'd0 },  // R4 exact expiry
    '{16'd100, 16'd40,  16'd90,   3'd0, 1'b0, 1'b0, 1'b1, 16'd0,   4'd0 },  // R4 overshoot, one-shot
    '{16'd100, 16'd40,  16'd40,   3'd0, 1'b1, 1'b0, 1'b1, 16'd100, 4'd0 },  // R6 zero surplus
    '{16'd100, 16'd40,  16'd390,  3'd0, 1'b1, 1'b0, 1'b1, 16'd50,  4'd3 },  // R6 three skipped
    '{16'd100, 16'd40,  16'd390,  3'd0, 1'b1, 1'b1, 1'b0, 16'd50,  4'd3 },  // R5 masked expiry
    '{16'd100, 16'd100, 16'd120,  3'd2, 1'b0, 1'b0, 1'b0, 16'd70,  4'd0 },  // R11 shift by 2
    '{16'd10,  16'd5,   16'd1000, 3'd0, 1'b1, 1'b0, 1'b1, 16'd5,   4'd15},  // R10 saturation
    '{16'd0,   16'd50,  16'd100,  3'd0, 1'b0, 1'b0, 1'b0, 16'd50,  4'd0 },  // R8 zero reload
    '{16'd7,   16'd7,   16'd28,   3'd2, 1'b1, 1'b0, 1'b1, 16'd7,   4'd0 }   // R11 + R6 scaled expiry
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input logic [CW-1:0] d, input logic [SW-1:0] sh, input logic pend);
    @(negedge clk);
    tick_valid = 1'b1; tick_delta = d; tick_shift = sh; irq_pend = pend;
    @(negedge clk);
    tick_valid = 1'b0; irq_pend = 1'b0;
    got_irq = irq_valid;
    got_vec = irq_vector;
    while (busy) @(negedge clk);
  endtask

  function automatic logic [CW-1:0] ctrl_word(input logic mask, input logic per,
                                              input logic [7:0] vec);
    return {{(CW-10){1'b0}}, mask, per, vec};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1 reset state
    chk("R1 cur", cur_count, 0);
    chk("R1 init", init_count, 0);
    chk("R1 missed", missed_count, 0);
    chk("R1 irq", irq_valid, 0);
    chk("R1 busy", busy, 0);

    // R2 write decoding
    wr(2'd0, 16'd77);
    chk("R2 reload write sets init", init_count, 77);
    chk("R2 reload write sets cur", cur_count, 77);
    wr(2'd1, 16'd20);
    chk("R2 count write leaves init", init_count, 77);
    chk("R2 count write sets cur", cur_count, 20);

    // table walk
    for (int i = 0; i < 10; i++) begin
      do_reset();
      wr(2'd0, TBL[i].init);
      wr(2'd1, TBL[i].cur);
      wr(2'd2, ctrl_word(TBL[i].mask, TBL[i].per, 8'h40 + 8'(i)));
      tick(TBL[i].delta, TBL[i].shift, 1'b0);
      chk($sformatf("R4 table %0d irq", i), got_irq, TBL[i].irq);
      if (TBL[i].irq)
        chk($sformatf("R2 table %0d vector", i), got_vec, 8'h40 + 8'(i));
      chk($sformatf("R6 table %0d cur", i), cur_count, TBL[i].cur_x);
      chk($sformatf("R10 table %0d missed", i), missed_count, TBL[i].miss_x);
    end

    // R8 one-shot at zero is stopped
    do_reset();
    wr(2'd0, 16'd100); wr(2'd1, 16'd40); wr(2'd2, ctrl_word(1'b0, 1'b0, 8'h21));
    tick(16'd50, 3'd0, 1'b0);
    tick(16'd5, 3'd0, 1'b0);
    chk("R8 stopped one-shot irq", got_irq, 0);
    chk("R8 stopped one-shot cur", cur_count, 0);

    // R7 replay gating
    do_reset();
    wr(2'd0, 16'd100); wr(2'd1, 16'd40); wr(2'd2, ctrl_word(1'b0, 1'b1, 8'h55));
    tick(16'd390, 3'd0, 1'b0);
    chk("R7 setup missed", missed_count, 3);
    tick(16'd10, 3'd0, 1'b1);
    chk("R7 pending blocks irq", got_irq, 0);
    chk("R7 pending keeps missed", missed_count, 3);
    chk("R3 cur after pending tick", cur_count, 40);
    tick(16'd10, 3'd0, 1'b0);
    chk("R7 replay irq", got_irq, 1);
    chk("R7 replay vector", got_vec, 8'h55);
    chk("R7 replay missed", missed_count, 2);
    chk("R3 cur after replay", cur_count, 30);
    wr(2'd2, ctrl_word(1'b1, 1'b1, 8'h55));
    tick(16'd10, 3'd0, 1'b0);
    chk("R7 mask blocks replay", got_irq, 0);
    chk("R7 mask keeps missed", missed_count, 2);

    // R9 dropped update while busy, R6 busy length
    do_reset();
    wr(2'd0, 16'd100); wr(2'd1, 16'd10); wr(2'd2, ctrl_word(1'b0, 1'b1, 8'h66));
    begin
      int n;
      logic extra_irq;
      @(negedge clk);
      tick_valid = 1'b1; tick_delta = 16'd1000; tick_shift = 3'd0;
      @(negedge clk);
      chk("R4 periodic expiry irq", irq_valid, 1);
      tick_delta = 16'd5;
      n = 0;
      extra_irq = 1'b0;
      while (busy && n < 100) begin
        n++;
        @(negedge clk);
        if (irq_valid) extra_irq = 1'b1;
      end
      tick_valid = 1'b0;
      chk("R6 busy cycles", n, CW);
      chk("R9 no irq while busy", extra_irq, 0);
      chk("R9 cur after drop", cur_count, 10);
      chk("R9 missed after drop", missed_count, 9);
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule